// File: doc/BRIEF.md
# Data Cache Line Maintenance Controller

This controller carries out one of three maintenance commands on a single data-cache line: zero-allocate, clean (copy a modified line out to memory), and flush (clean, then drop the line). With each command it receives the effective address, the page attributes (write-through, caching-inhibited, coherence-required), a configuration bit that enables broadcasts for clean lines, and the outcome of the tag lookup: a hit flag and the line's modified flag. It answers with line-array actions, a write-back request with a ready/acknowledge handshake, an address-only broadcast request and an alignment-exception flag.

Zero-allocate never reads memory. It writes the line as eight zero words, one per cycle, and marks the line modified. On a miss it also allocates the line. Clean and flush hold `busy` while a write-back is outstanding. The controller takes one command at a time. A command offered while `busy` is high is dropped.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: Zero-allocate (op code 00) to a page that is neither write-through nor caching-inhibited, when the lookup misses, pulses `line_alloc` for one cycle in the cycle after acceptance. In that same cycle it begins eight zero-data word writes, with `word_idx` counting 0 to 7 on consecutive cycles.
- R2: Zero-allocate to a write-through or caching-inhibited page pulses `align_exc` for one cycle. It produces no allocation, no word write and no broadcast, and it leaves `busy` low.
- R3: Zero-allocate to a cacheable, coherence-required page pulses `bcast_req` together with the start of the zeroing. Without coherence-required, no broadcast is issued.
- R4: Zero-allocate on a hit zeroes the existing line without allocating. On both hit and miss, `line_set_dirty` pulses once, alongside the word write with index 7.
- R5: Clean (op code 01) on a modified hit holds `wb_req` from the cycle after acceptance until `wb_ack` is sampled high. In the next cycle `line_clean` pulses, `line_inval` stays low and `busy` is low.
- R6: Clean with no write-back due (a miss, or a hit on an unmodified line) pulses `bcast_req` only when both `bcast_en` and the coherence-required attribute are set. Otherwise it produces no output action.
- R7: The clean command does not depend on the write-through or caching-inhibited attributes.
- R8: Flush (op code 10) on an unmodified hit pulses `line_inval` in the cycle after acceptance and requests no write-back.
- R9: Flush on a modified hit holds `wb_req` until `wb_ack`. In the following cycle it pulses `line_inval`, with `line_clean` low.
- R10: Flush on a miss produces no action, whatever the caching-inhibited and coherence attributes are.
- R11: While `busy` is high, `cmd_valid` is ignored.
- R12: `line_addr` is the accepted command address with its low five bits cleared (32-byte line).
- R13: Op code 11 is accepted and produces no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | 00 zero-allocate, 01 clean, 10 flush, 11 none |
| cmd_addr | input | 32 | Effective byte address |
| pg_wt | input | 1 | Page is write-through |
| pg_ci | input | 1 | Page is caching-inhibited |
| pg_coh | input | 1 | Page is coherence-required |
| bcast_en | input | 1 | Enables broadcast for a clean without write-back |
| lk_hit | input | 1 | Lookup hit for the addressed line |
| lk_dirty | input | 1 | Looked-up line is modified |
| busy | output | 1 | Command in progress |
| line_addr | output | 32 | Line-aligned address of the current command |
| line_alloc | output | 1 | Allocate the line (pulse) |
| line_set_dirty | output | 1 | Mark the line modified (pulse) |
| line_inval | output | 1 | Invalidate the line (pulse) |
| line_clean | output | 1 | Clear the line's modified bit (pulse) |
| word_we | output | 1 | Line word write strobe |
| word_idx | output | 3 | Word index within the line |
| word_data | output | 32 | Word write data (zero) |
| wb_req | output | 1 | Write-back request |
| wb_ack | input | 1 | Write-back done |
| bcast_req | output | 1 | Address-only bus transaction request (pulse) |
| align_exc | output | 1 | Alignment exception (pulse) |

## Verification
A command counts as accepted at the clock edge where `cmd_valid` is sampled high with `busy` low. Its immediate results appear in the cycle that follows that edge: `align_exc`, `line_alloc`, `bcast_req`, `line_inval`, the first zero write and `wb_req`. Word writes then run for eight consecutive cycles, and `busy` falls in the ninth. The completion pulse of a write-back appears in the cycle after the edge that samples `wb_ack`. Each task therefore applies a command at a falling edge and checks the immediate results at the next falling edge. Pulse counts are gathered one nanosecond after each falling edge and compared after a fixed settling window that covers the longest sequence.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'b00,
        OP_CLEAN = 2'b01,
        OP_FLUSH = 2'b10,
        OP_NONE  = 2'b11
    } maint_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ZERO,
        ST_WB
    } ctl_state_e;

    typedef enum logic {
        POST_CLEAN,
        POST_INVAL
    } wb_post_e;

    typedef struct packed {
        logic wt;
        logic ci;
        logic coh;
    } page_attr_t;

    typedef struct packed {
        logic     exc;
        logic     zero;
        logic     alloc;
        logic     bcast;
        logic     inval;
        logic     wb;
        wb_post_e post;
    } maint_plan_t;

    function automatic maint_plan_t plan_idle();
        maint_plan_t p;
        p = '{exc: 1'b0, zero: 1'b0, alloc: 1'b0, bcast: 1'b0,
              inval: 1'b0, wb: 1'b0, post: POST_CLEAN};
        return p;
    endfunction

endpackage

// File: rtl/cmaint_decode.sv
module cmaint_decode
    import cmaint_pkg::*;
(
    input  maint_op_e   op,
    input  page_attr_t  attr,
    input  logic        bcast_en,
    input  logic        hit,
    input  logic        dirty,
    output maint_plan_t plan
);
    always_comb begin
        plan = plan_idle();
        unique case (op)
            OP_ZERO: begin
                if (attr.ci || attr.wt) begin
                    plan.exc = 1'b1;
                end else begin
                    plan.zero  = 1'b1;
                    plan.alloc = !hit;
                    plan.bcast = attr.coh;
                end
            end
            OP_CLEAN: begin
                if (hit && dirty) begin
                    plan.wb   = 1'b1;
                    plan.post = POST_CLEAN;
                end else begin
                    plan.bcast = bcast_en && attr.coh;
                end
            end
            OP_FLUSH: begin
                if (hit && dirty) begin
                    plan.wb   = 1'b1;
                    plan.post = POST_INVAL;
                end else if (hit) begin
                    plan.inval = 1'b1;
                end
            end
            default: plan = plan_idle();
        endcase
    end
endmodule

// File: rtl/cmaint_zero_seq.sv
module cmaint_zero_seq #(
    parameter int WORDS = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             we,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic             active;
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST_IDX) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign we   = active;
    assign idx  = cnt;
    assign last = active && (cnt == LAST_IDX);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);  // R11
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
    import cmaint_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORD_W     = 32,
    localparam int WORDS     = LINE_BYTES * 8 / WORD_W,
    localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              pg_wt,
    input  logic              pg_ci,
    input  logic              pg_coh,
    input  logic              bcast_en,
    input  logic              lk_hit,
    input  logic              lk_dirty,
    output logic              busy,
    output logic [ADDR_W-1:0] line_addr,
    output logic              line_alloc,
    output logic              line_set_dirty,
    output logic              line_inval,
    output logic              line_clean,
    output logic              word_we,
    output logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] word_data,
    output logic              wb_req,
    input  logic              wb_ack,
    output logic              bcast_req,
    output logic              align_exc
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORDS - 1);

    ctl_state_e  state;
    maint_plan_t plan;
    page_attr_t  attr;
    wb_post_e    post_q;
    logic        accept;
    logic        seq_last;
    logic        alloc_q, bcast_q, inval_q, clean_q, exc_q;
    logic [ADDR_W-1:0] addr_q;

    assign attr   = '{wt: pg_wt, ci: pg_ci, coh: pg_coh};
    assign accept = cmd_valid && (state == ST_IDLE);

    cmaint_decode u_decode (
        .op       (maint_op_e'(cmd_op)),
        .attr     (attr),
        .bcast_en (bcast_en),
        .hit      (lk_hit),
        .dirty    (lk_dirty),
        .plan     (plan)
    );

    cmaint_zero_seq #(.WORDS(WORDS)) u_zero_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept && plan.zero),
        .we    (word_we),
        .idx   (word_idx),
        .last  (seq_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            post_q  <= POST_CLEAN;
            alloc_q <= 1'b0;
            bcast_q <= 1'b0;
            inval_q <= 1'b0;
            clean_q <= 1'b0;
            exc_q   <= 1'b0;
        end else begin
            alloc_q <= 1'b0;
            bcast_q <= 1'b0;
            inval_q <= 1'b0;
            clean_q <= 1'b0;
            exc_q   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= cmd_addr & ~OFF_MASK;
                        post_q  <= plan.post;
                        exc_q   <= plan.exc;
                        alloc_q <= plan.alloc;
                        bcast_q <= plan.bcast;
                        inval_q <= plan.inval;
                        if (plan.zero)    state <= ST_ZERO;
                        else if (plan.wb) state <= ST_WB;
                    end
                end
                ST_ZERO: begin
                    if (seq_last) state <= ST_IDLE;
                end
                ST_WB: begin
                    if (wb_ack) begin
                        state   <= ST_IDLE;
                        clean_q <= (post_q == POST_CLEAN);
                        inval_q <= (post_q == POST_INVAL);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy           = (state != ST_IDLE);
    assign line_addr      = addr_q;
    assign line_alloc     = alloc_q;
    assign line_inval     = inval_q;
    assign line_clean     = clean_q;
    assign bcast_req      = bcast_q;
    assign align_exc      = exc_q;
    assign wb_req         = (state == ST_WB);
    assign word_data      = '0;
    assign line_set_dirty = seq_last;

    AST_EXC_QUIET: assert property (@(posedge clk) disable iff (rst)
        align_exc |-> !busy && !line_alloc && !word_we && !bcast_req);  // R2
    AST_ALLOC_FIRST: assert property (@(posedge clk) disable iff (rst)
        line_alloc |-> word_we && (word_idx == '0));  // R1
    AST_DIRTY_LAST: assert property (@(posedge clk) disable iff (rst)
        line_set_dirty |-> word_we && (word_idx == LAST_IDX));  // R4
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_req && !wb_ack |=> wb_req);  // R5
    AST_WB_FINISH: assert property (@(posedge clk) disable iff (rst)
        wb_req && wb_ack |=> !busy && (line_clean != line_inval));  // R9
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(wb_req && word_we));  // R11
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (line_addr & OFF_MASK) == '0);  // R12
endmodule

// File: tb/dcache_maint_ctrl_bench.sv
`timescale 1ns/1ps
module dcache_maint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic        pg_wt, pg_ci, pg_coh, bcast_en, lk_hit, lk_dirty;
    logic        busy;
    logic [31:0] line_addr;
    logic        line_alloc, line_set_dirty, line_inval, line_clean;
    logic        word_we;
    logic [2:0]  word_idx;
    logic [31:0] word_data;
    logic        wb_req, wb_ack, bcast_req, align_exc;

    int checks = 0;
    int errors = 0;
    int n_alloc, n_dirty, n_inval, n_clean, n_we, n_bcast, n_exc, n_wb, n_bad;
    int exp_idx;

    always #5 clk = ~clk;

    dcache_maint_ctrl u_dcache_maint_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .pg_wt(pg_wt), .pg_ci(pg_ci), .pg_coh(pg_coh),
        .bcast_en(bcast_en), .lk_hit(lk_hit), .lk_dirty(lk_dirty),
        .busy(busy), .line_addr(line_addr), .line_alloc(line_alloc),
        .line_set_dirty(line_set_dirty), .line_inval(line_inval),
        .line_clean(line_clean), .word_we(word_we), .word_idx(word_idx),
        .word_data(word_data), .wb_req(wb_req), .wb_ack(wb_ack),
        .bcast_req(bcast_req), .align_exc(align_exc)
    );

    always @(negedge clk) begin
        #1;
        n_alloc += int'(line_alloc);
        n_dirty += int'(line_set_dirty);
        n_inval += int'(line_inval);
        n_clean += int'(line_clean);
        n_bcast += int'(bcast_req);
        n_exc   += int'(align_exc);
        n_wb    += int'(wb_req);
        if (word_we) begin
            n_we++;
            if (int'(word_idx) != exp_idx || word_data != 32'd0) n_bad++;
            exp_idx = (exp_idx + 1) % 8;
        end
    end

    task automatic clear_counts();
        n_alloc = 0; n_dirty = 0; n_inval = 0; n_clean = 0; n_we = 0;
        n_bcast = 0; n_exc = 0; n_wb = 0; n_bad = 0; exp_idx = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic send(input logic [1:0] op, input logic [31:0] a,
                        input logic wt, input logic ci, input logic coh,
                        input logic be, input logic hit, input logic dirty);
        cmd_op = op; cmd_addr = a; pg_wt = wt; pg_ci = ci; pg_coh = coh;
        bcast_en = be; lk_hit = hit; lk_dirty = dirty; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        clear_counts();
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 busy after reset", int'(busy), 0);
        chk("R5 wb_req after reset", int'(wb_req), 0);
        chk("R1 word_we after reset", int'(word_we), 0);
        chk("R2 align_exc after reset", int'(align_exc), 0);
    endtask

    task automatic t_zero_miss();
        send(2'b00, 32'h0000_1234, 0, 0, 0, 0, 0, 0);
        chk("R1 alloc pulse", int'(line_alloc), 1);
        chk("R1 first word", int'(word_we), 1);
        chk("R1 busy", int'(busy), 1);
        chk("R12 line_addr", int'(line_addr), 32'h0000_1220);
        settle();
        chk("R1 word count", n_we, 8);
        chk("R1 word order/data", n_bad, 0);
        chk("R1 alloc count", n_alloc, 1);
        chk("R4 dirty mark", n_dirty, 1);
        chk("R3 no broadcast without coh", n_bcast, 0);
        chk("R1 idle after", int'(busy), 0);
    endtask

    task automatic t_zero_coh();
        send(2'b00, 32'hABCD_EF5F, 0, 0, 1, 0, 0, 0);
        chk("R3 broadcast with alloc", int'(bcast_req), 1);
        chk("R12 line_addr", int'(line_addr), 32'hABCD_EF40);
        settle();
        chk("R3 broadcast count", n_bcast, 1);
        chk("R3 words", n_we, 8);
    endtask

    task automatic t_zero_hit();
        send(2'b00, 32'h0000_0040, 0, 0, 0, 0, 1, 0);
        settle();
        chk("R4 no alloc on hit", n_alloc, 0);
        chk("R4 words on hit", n_we, 8);
        chk("R4 order on hit", n_bad, 0);
        chk("R4 dirty on hit", n_dirty, 1);
    endtask

    task automatic t_zero_exc(input logic wt, input logic ci);
        send(2'b00, 32'h0000_0080, wt, ci, 1, 0, 0, 0);
        chk("R2 exception pulse", int'(align_exc), 1);
        chk("R2 not busy", int'(busy), 0);
        settle();
        chk("R2 exception count", n_exc, 1);
        chk("R2 no words", n_we, 0);
        chk("R2 no alloc", n_alloc, 0);
        chk("R2 no broadcast", n_bcast, 0);
    endtask

    task automatic t_clean_dirty(input logic wt, input logic ci);
        send(2'b01, 32'h0000_0100, wt, ci, 0, 0, 1, 1);
        chk("R5 wb_req raised", int'(wb_req), 1);
        repeat (3) @(negedge clk);
        chk("R5 wb_req held", int'(wb_req), 1);
        chk("R7 busy during wb", int'(busy), 1);
        chk("R5 no early clean", n_clean, 0);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        chk("R5 clean pulse", int'(line_clean), 1);
        chk("R5 no inval", int'(line_inval), 0);
        chk("R5 wb_req dropped", int'(wb_req), 0);
        chk("R5 idle", int'(busy), 0);
    endtask

    task automatic t_clean_nowb(input logic hit, input logic be, input logic coh,
                                input int exp_b);
        send(2'b01, 32'h0000_0200, 1, 0, coh, be, hit, 0);
        settle();
        chk("R6 broadcast", n_bcast, exp_b);
        chk("R6 no wb", n_wb, 0);
        chk("R6 no clean/inval", n_clean + n_inval, 0);
    endtask

    task automatic t_flush_clean();
        send(2'b10, 32'h0000_0300, 0, 1, 1, 1, 1, 0);
        chk("R8 inval pulse", int'(line_inval), 1);
        chk("R8 no wb", int'(wb_req), 0);
        settle();
        chk("R8 inval count", n_inval, 1);
    endtask

    task automatic t_flush_dirty();
        send(2'b10, 32'h0000_0400, 0, 0, 0, 0, 1, 1);
        chk("R9 wb_req", int'(wb_req), 1);
        chk("R9 no early inval", int'(line_inval), 0);
        @(negedge clk);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        chk("R9 inval after ack", int'(line_inval), 1);
        chk("R9 no clean", int'(line_clean), 0);
        chk("R9 idle", int'(busy), 0);
    endtask

    task automatic t_flush_miss(input logic ci, input logic coh);
        send(2'b10, 32'h0000_0500, 0, ci, coh, 1, 0, 0);
        settle();
        chk("R10 no action", n_inval + n_clean + n_wb + n_bcast + n_we + n_exc, 0);
    endtask

    task automatic t_busy_ignore();
        send(2'b00, 32'h0000_0600, 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        cmd_op = 2'b10; lk_hit = 1'b1; lk_dirty = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        settle();
        chk("R11 command during busy dropped", n_inval, 0);
        chk("R11 zeroing intact", n_we, 8);
        chk("R11 line_addr kept", int'(line_addr), 32'h0000_0600);
    endtask

    task automatic t_op_none();
        send(2'b11, 32'h0000_0700, 0, 0, 1, 1, 1, 1);
        chk("R13 not busy", int'(busy), 0);
        settle();
        chk("R13 no action",
            n_alloc + n_inval + n_clean + n_wb + n_bcast + n_we + n_exc, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b11; cmd_addr = '0;
        pg_wt = 0; pg_ci = 0; pg_coh = 0; bcast_en = 0; lk_hit = 0;
        lk_dirty = 0; wb_ack = 0;
        clear_counts();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_miss();
        t_zero_coh();
        t_zero_hit();
        t_zero_exc(1'b1, 1'b0);
        t_zero_exc(1'b0, 1'b1);
        t_clean_dirty(1'b0, 1'b0);
        t_clean_dirty(1'b1, 1'b1);
        t_clean_nowb(1'b1, 1'b1, 1'b1, 1);
        t_clean_nowb(1'b1, 1'b0, 1'b1, 0);
        t_clean_nowb(1'b1, 1'b1, 1'b0, 0);
        t_clean_nowb(1'b0, 1'b1, 1'b1, 1);
        t_flush_clean();
        t_flush_dirty();
        t_flush_miss(1'b1, 1'b1);
        t_flush_miss(1'b0, 1'b0);
        t_busy_ignore();
        t_op_none();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule